// File: doc/BRIEF.md
# Two-Write One-Read Synchronous RAM

This block is a synchronous RAM with two write ports and one read port. Each port has its own address. True storage with two write ports is costly, so the block holds two ordinary single-write copies of the array. Port A writes only its own copy and port B writes only its own copy. A one-bit-per-word ownership table records which port most recently wrote each word.

A read fetches the word at the read address from both copies and looks up the ownership bit in the same cycle. All three results are registered together, so the registered bit picks between the two registered words one clock later. Each write port can be used on its own or together with the other. When both ports write the same word in one cycle, the rule in R5 decides which value is kept.

Top module: `dual_write_ram`

## Requirements
- R1: While reset (rst_n low) is asserted, rd_data is all zeros. The ownership table clears to 0, which means port A.
- R2: A word written through port A, with no port B write to that address in the same cycle, appears on rd_data one clock after that address is presented on rd_addr.
- R3: A word written through port B appears on rd_data one clock after that address is presented on rd_addr.
- R4: When a word is written by both ports in different cycles, the most recent write decides the value that is read, whatever the order of the two ports.
- R5: When both ports write the same address in the same cycle, the port B data is the value read back.
- R6: When both ports write different addresses in the same cycle, both words are kept.
- R7: A read of an address that is written in the same cycle returns the old contents. The new contents are returned from the next read.
- R8: When a port's write enable is low, its address and data have no effect on any stored word.
- R9: Read latency is exactly one clock. rd_data changes only at a clock edge, and it reflects the rd_addr sampled at that edge. With a stable read address and no writes, rd_data stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wa_en | input | 1 | Port A write enable, active high |
| wa_addr | input | ADDR_W | Port A write address |
| wa_data | input | DATA_W | Port A write data |
| wb_en | input | 1 | Port B write enable, active high |
| wb_addr | input | ADDR_W | Port B write address |
| wb_data | input | DATA_W | Port B write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data |

## Verification
The temporal checks assume that both write enables are held low while reset is asserted. They also assume that at least two clean clock edges have passed after reset before a write-to-read relation is judged. A counter in the checker arms the checks only after those edges. The bench drives every input on the falling edge, keeps the enables low throughout reset, and reads only words it has written first. As a result, no check ever sees the undefined contents of the uninitialised arrays.

// File: rtl/dwr_pkg.sv
package dwr_pkg;
    // Meaning of one ownership-table bit
    typedef enum logic {
        OWNER_A = 1'b0,
        OWNER_B = 1'b1
    } owner_e;

    localparam int unsigned NUM_WR_PORTS = 2;
endpackage

// File: rtl/dwr_bank.sv
// One single-write copy of the array with a registered read word.
module dwr_bank #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 64,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);
    typedef struct packed {
        logic [DATA_W-1:0] word;
    } bank_state_t;

    logic [DATA_W-1:0] mem_q [DEPTH];
    bank_state_t       st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.word = mem_q[rd_addr];   // old contents: read before write
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    assign rd_word = st_q.word;
endmodule

// File: rtl/dwr_owner_table.sv
// Per-word record of which write port wrote last, plus registered lookup.
module dwr_owner_table #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wa_en,
    input  logic [ADDR_W-1:0] wa_addr,
    input  logic              wb_en,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output dwr_pkg::owner_e   rd_owner
);
    import dwr_pkg::*;

    typedef struct packed {
        logic [DEPTH-1:0] owner;
        logic             sel;
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.sel = st_q.owner[rd_addr];          // lookup before update
        if (wa_en) st_d.owner[wa_addr] = OWNER_A;
        if (wb_en) st_d.owner[wb_addr] = OWNER_B; // applied last: B wins a tie
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_owner = owner_e'(st_q.sel);
endmodule

// File: rtl/dual_write_ram.sv
module dual_write_ram #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 64,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wa_en,
    input  logic [ADDR_W-1:0] wa_addr,
    input  logic [DATA_W-1:0] wa_data,
    input  logic              wb_en,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    import dwr_pkg::*;

    logic              port_en   [NUM_WR_PORTS];
    logic [ADDR_W-1:0] port_addr [NUM_WR_PORTS];
    logic [DATA_W-1:0] port_data [NUM_WR_PORTS];
    logic [DATA_W-1:0] copy_word [NUM_WR_PORTS];
    owner_e            owner_sel;

    assign port_en[0]   = wa_en;
    assign port_addr[0] = wa_addr;
    assign port_data[0] = wa_data;
    assign port_en[1]   = wb_en;
    assign port_addr[1] = wb_addr;
    assign port_data[1] = wb_data;

    for (genvar p = 0; p < NUM_WR_PORTS; p++) begin : g_copy
        dwr_bank #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (port_en[p]),
            .wr_addr (port_addr[p]),
            .wr_data (port_data[p]),
            .rd_addr (rd_addr),
            .rd_word (copy_word[p])
        );
    end

    dwr_owner_table #(
        .DEPTH (DEPTH)
    ) u_owner (
        .clk      (clk),
        .rst_n    (rst_n),
        .wa_en    (wa_en),
        .wa_addr  (wa_addr),
        .wb_en    (wb_en),
        .wb_addr  (wb_addr),
        .rd_addr  (rd_addr),
        .rd_owner (owner_sel)
    );

    always_comb begin
        rd_data = (owner_sel == OWNER_B) ? copy_word[1] : copy_word[0];
    end
endmodule

// File: rtl/dwr_ram_chk.sv
module dwr_ram_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wa_en,
    input logic [ADDR_W-1:0] wa_addr,
    input logic [DATA_W-1:0] wa_data,
    input logic              wb_en,
    input logic [ADDR_W-1:0] wb_addr,
    input logic [DATA_W-1:0] wb_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data
);
    logic [1:0] edges_q;
    logic       armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              edges_q <= 2'd0;
        else if (edges_q != 2'd2) edges_q <= edges_q + 2'd1;
    end
    assign armed = (edges_q == 2'd2);

    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_reset_zero: assert (rd_data == '0);
        end
    end

    a_r2_port_a_visible: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(wa_en) && !($past(wb_en) && ($past(wb_addr) == $past(wa_addr)))
         && (rd_addr == $past(wa_addr)))
        |=> (rd_data == $past(wa_data, 2)));

    a_r5_port_b_visible: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(wb_en) && (rd_addr == $past(wb_addr)))
        |=> (rd_data == $past(wb_data, 2)));

    a_r9_stable_read: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (!$past(wa_en) && !$past(wb_en) && $stable(rd_addr))
        |=> $stable(rd_data));
endmodule

bind dual_write_ram dwr_ram_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wa_en   (wa_en),
    .wa_addr (wa_addr),
    .wa_data (wa_data),
    .wb_en   (wb_en),
    .wb_addr (wb_addr),
    .wb_data (wb_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
);

// File: tb/dual_write_ram_tb.sv
`timescale 1ns/1ps
module dual_write_ram_tb;
    localparam int unsigned DW = 16;
    localparam int unsigned AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wa_en = 1'b0, wb_en = 1'b0;
    logic [AW-1:0] wa_addr = '0, wb_addr = '0, rd_addr = '0;
    logic [DW-1:0] wa_data = '0, wb_data = '0;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dual_write_ram #(.DATA_W(DW), .DEPTH(64)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rd_data=%h expected=%h", req, act, exp);
        end
    endtask

    // Entered just after a falling edge; returns just after the next one.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write(input bit ae, input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                         input bit be, input logic [AW-1:0] ba, input logic [DW-1:0] bd);
        wa_en = ae; wa_addr = aa; wa_data = ad;
        wb_en = be; wb_addr = ba; wb_data = bd;
        step();
        wa_en = 1'b0; wb_en = 1'b0;
    endtask

    task automatic read_expect(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        rd_addr = a;
        step();
        check(req, rd_data, exp);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1", rd_data, '0);
        end
        rst_n = 1'b1;
        step(); step();
    endtask

    task automatic t_port_a();
        write(1, 6'd3, 16'h1111, 0, 6'd0, 16'h0);
        read_expect("R2", 6'd3, 16'h1111);
    endtask

    task automatic t_port_b();
        write(0, 6'd0, 16'h0, 1, 6'd5, 16'h5555);
        read_expect("R3", 6'd5, 16'h5555);
    endtask

    task automatic t_override();
        write(1, 6'd7, 16'hA001, 0, 6'd0, 16'h0);
        write(0, 6'd0, 16'h0, 1, 6'd7, 16'hB002);
        read_expect("R4 A then B", 6'd7, 16'hB002);
        write(1, 6'd7, 16'hA003, 0, 6'd0, 16'h0);
        read_expect("R4 B then A", 6'd7, 16'hA003);
        write(0, 6'd0, 16'h0, 1, 6'd63, 16'hB063);
        write(1, 6'd63, 16'hA063, 0, 6'd0, 16'h0);
        read_expect("R4 top address", 6'd63, 16'hA063);
    endtask

    task automatic t_collision();
        write(1, 6'd9, 16'hAAAA, 1, 6'd9, 16'hBBBB);
        read_expect("R5 same address", 6'd9, 16'hBBBB);
        write(1, 6'd0, 16'h0A0A, 1, 6'd0, 16'h0B0B);
        read_expect("R5 address zero", 6'd0, 16'h0B0B);
    endtask

    task automatic t_parallel();
        write(1, 6'd10, 16'h1010, 1, 6'd11, 16'h2011);
        read_expect("R6 port A word", 6'd10, 16'h1010);
        read_expect("R6 port B word", 6'd11, 16'h2011);
    endtask

    task automatic t_read_before_write();
        rd_addr = 6'd3;
        write(1, 6'd3, 16'h2222, 0, 6'd0, 16'h0);
        check("R7 old value", rd_data, 16'h1111);
        read_expect("R7 new value", 6'd3, 16'h2222);
        rd_addr = 6'd5;
        write(0, 6'd0, 16'h0, 1, 6'd5, 16'h5A5A);
        check("R7 old value port B", rd_data, 16'h5555);
        read_expect("R7 new value port B", 6'd5, 16'h5A5A);
    endtask

    task automatic t_enable_low();
        write(0, 6'd3, 16'h9999, 0, 6'd3, 16'h8888);
        read_expect("R8 disabled writes", 6'd3, 16'h2222);
        write(0, 6'd9, 16'h7777, 0, 6'd0, 16'h0);
        read_expect("R8 port A disabled on B word", 6'd9, 16'hBBBB);
    endtask

    task automatic t_latency();
        read_expect("R9 setup", 6'd10, 16'h1010);
        rd_addr = 6'd11;
        #1;
        check("R9 no change before edge", rd_data, 16'h1010);
        step();
        check("R9 change after one edge", rd_data, 16'h2011);
        step();
        check("R9 stable", rd_data, 16'h2011);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_port_a();
        t_port_b();
        t_override();
        t_collision();
        t_parallel();
        t_read_before_write();
        t_enable_low();
        t_latency();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule